// File: doc/BRIEF.md
# Clock Generator Digital Loop Filter

This block closes the frequency loop of a clock generator in the digital domain. Each cycle it takes one decision from a bang-bang phase-frequency detector: raise the oscillator frequency, lower it, or leave it. The decision comes from comparing a reference clock with the divided oscillator clock. A saturating accumulator integrates these decisions, each step weighted by a programmable gain. The accumulator word is then cut into three fields. The upper field drives the oscillator's coarse band select. The middle field is the fine tuning code. The lower field is a fractional residue that a first-order delta-sigma modulator turns into an occasional extra fine-code LSB.

The fine code leaves the block in two parts. Its low bits drive binary-weighted elements. Its high bits drive unit elements through a thermometer code, so that the large steps switch without glitches. The gain and a few control bits live in a small register file. It can be written at any time while the loop runs. A write takes effect from the next update.

Top module: `cg_loop_filter`

## Requirements
- R1: After reset the accumulator is mid-scale (only its top bit set). The gain register is 1 and all control bits are clear. The outputs read coarse 32, fine binary 0 and thermometer all zero.
- R2: On a clock edge with up asserted and down clear, the accumulator grows by the gain register. With down asserted and up clear it shrinks by the gain. With both or neither asserted it holds.
- R3: The accumulator saturates at its all-ones maximum and at zero instead of wrapping.
- R4: The coarse output equals the top 6 accumulator bits as they stood one clock edge earlier.
- R5: The 5-bit fine code is split in two. Its low 2 bits appear on the binary output. Its upper 3 bits, of value k, appear as exactly k ones on the 7 thermometer lines, filled from line 0 upward. All fields change on the same edge.
- R6: With dithering enabled, a 5-bit fraction accumulator adds the accumulator's low 5 bits on every edge. Its carry-out adds one LSB to the fine code, and the fine code saturates at 31. With dithering disabled the fraction accumulator is cleared and no carry is added.
- R7: A register write at address 0 sets the 8-bit gain. A write at address 1 sets the control bits: bit 0 enables dithering, bit 1 freezes the accumulator, bit 2 inverts the detector polarity. A new value governs updates from the edge after the write. Writes to addresses 2 and 3 are ignored.
- R8: While the freeze bit is set, the accumulator holds regardless of the detector inputs.
- R9: While the polarity bit is set, the roles of up and down are swapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Filter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_i | input | 1 | Detector decision: raise frequency |
| dn_i | input | 1 | Detector decision: lower frequency |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register address |
| cfg_wdata_i | input | 8 | Register write data |
| coarse_o | output | 6 | Coarse band select code |
| fine_bin_o | output | 2 | Binary-weighted fine segment |
| fine_therm_o | output | 7 | Thermometer-coded fine segment |

## Verification
The bench builds the block with its defaults. The accumulator is 16 bits, giving 6 coarse, 5 fine and 5 fractional bits, and the gain is 8 bits. With these widths a gain of 255 reaches either saturation limit in a few hundred cycles, so both rails are exercised directly. A gain of 32 moves the fine code by exactly one step, which puts the binary-to-thermometer boundary and the dither carry into the top fine code within easy reach. Random detector decisions, gain changes and control writes run against a cycle model in the bench.

// File: rtl/cgf_pkg.sv
package cgf_pkg;

    typedef struct packed {
        logic invert;
        logic freeze;
        logic dither;
    } cgf_ctrl_t;

    localparam logic [1:0] ADDR_GAIN = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;

endpackage

// File: rtl/cgf_regs.sv
module cgf_regs
    import cgf_pkg::*;
#(
    parameter int GAIN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [1:0]        addr_i,
    input  logic [GAIN_W-1:0] wdata_i,
    output logic [GAIN_W-1:0] gain_o,
    output cgf_ctrl_t         ctrl_o
);
    typedef struct packed {
        logic [GAIN_W-1:0] gain;
        cgf_ctrl_t         ctrl;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we_i && addr_i == ADDR_GAIN) s_d.gain = wdata_i;
        if (we_i && addr_i == ADDR_CTRL) s_d.ctrl = cgf_ctrl_t'(wdata_i[2:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.gain <= GAIN_W'(1);
            s_q.ctrl <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign gain_o = s_q.gain;
    assign ctrl_o = s_q.ctrl;

    p_ignore_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i[1]) |=> ($stable(gain_o) && $stable(ctrl_o)));
endmodule

// File: rtl/cgf_accum.sv
module cgf_accum #(
    parameter int ACC_W  = 16,
    parameter int GAIN_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc_i,
    input  logic              dec_i,
    input  logic              freeze_i,
    input  logic [GAIN_W-1:0] gain_i,
    output logic [ACC_W-1:0]  acc_o
);
    localparam logic [ACC_W-1:0] ACC_MAX = '1;
    localparam logic [ACC_W-1:0] ACC_MID = ACC_W'(1) << (ACC_W-1);

    logic [ACC_W-1:0] acc_d, acc_q;
    logic [ACC_W:0]   sum_w;
    logic [ACC_W-1:0] gain_w;

    always_comb begin
        gain_w = ACC_W'(gain_i);
        sum_w  = {1'b0, acc_q} + {1'b0, gain_w};
        acc_d  = acc_q;
        if (!freeze_i && inc_i && !dec_i)
            acc_d = sum_w[ACC_W] ? ACC_MAX : sum_w[ACC_W-1:0];
        else if (!freeze_i && dec_i && !inc_i)
            acc_d = (acc_q < gain_w) ? '0 : acc_q - gain_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= ACC_MID;
        else        acc_q <= acc_d;
    end

    assign acc_o = acc_q;

    p_sat_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !dec_i && acc_q == ACC_MAX) |=> acc_q == ACC_MAX);
    p_sat_bottom_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !inc_i && acc_q == '0) |=> acc_q == '0);
    p_freeze_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        freeze_i |=> $stable(acc_q));
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i == dec_i) |=> $stable(acc_q));
endmodule

// File: rtl/cgf_dsm.sv
module cgf_dsm #(
    parameter int FRAC_W = 5,
    parameter int FINE_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [FRAC_W-1:0] frac_i,
    input  logic [FINE_W-1:0] fine_i,
    output logic [FINE_W-1:0] fine_o
);
    localparam logic [FINE_W-1:0] FINE_MAX = '1;

    logic [FRAC_W-1:0] frac_d, frac_q;
    logic [FRAC_W:0]   fsum_w;
    logic              carry_w;

    always_comb begin
        fsum_w  = {1'b0, frac_q} + {1'b0, frac_i};
        carry_w = en_i & fsum_w[FRAC_W];
        frac_d  = en_i ? fsum_w[FRAC_W-1:0] : '0;
        if (carry_w && fine_i != FINE_MAX) fine_o = fine_i + FINE_W'(1);
        else                               fine_o = fine_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) frac_q <= '0;
        else        frac_q <= frac_d;
    end

    p_off_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> frac_q == '0);
    p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fine_o >= fine_i);
endmodule

// File: rtl/cgf_therm.sv
module cgf_therm #(
    parameter int IN_W = 3
) (
    input  logic [IN_W-1:0]       code_i,
    output logic [(1<<IN_W)-2:0]  lines_o
);
    localparam int LINES = (1 << IN_W) - 1;

    for (genvar i = 0; i < LINES; i++) begin : g_line
        assign lines_o[i] = ({1'b0, code_i} > (IN_W+1)'(i));
    end
endmodule

// File: rtl/cg_loop_filter.sv
module cg_loop_filter
    import cgf_pkg::*;
#(
    parameter int ACC_W    = 16,
    parameter int COARSE_W = 6,
    parameter int BIN_W    = 2,
    parameter int THERM_W  = 3,
    parameter int GAIN_W   = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      up_i,
    input  logic                      dn_i,
    input  logic                      cfg_we_i,
    input  logic [1:0]                cfg_addr_i,
    input  logic [GAIN_W-1:0]         cfg_wdata_i,
    output logic [COARSE_W-1:0]       coarse_o,
    output logic [BIN_W-1:0]          fine_bin_o,
    output logic [(1<<THERM_W)-2:0]   fine_therm_o
);
    localparam int FINE_W = BIN_W + THERM_W;
    localparam int FRAC_W = ACC_W - COARSE_W - FINE_W;
    localparam int LINES  = (1 << THERM_W) - 1;
    localparam logic [COARSE_W-1:0] COARSE_RST = COARSE_W'(1) << (COARSE_W-1);

    typedef struct packed {
        logic [COARSE_W-1:0] coarse;
        logic [BIN_W-1:0]    bin;
        logic [LINES-1:0]    therm;
    } out_t;

    logic [GAIN_W-1:0] gain_w;
    cgf_ctrl_t         ctrl_w;
    logic              inc_w, dec_w;
    logic [ACC_W-1:0]  acc_w;
    logic [FINE_W-1:0] fine_w;
    logic [LINES-1:0]  therm_w;
    out_t              out_d, out_q;

    cgf_regs #(.GAIN_W(GAIN_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
        .wdata_i(cfg_wdata_i), .gain_o(gain_w), .ctrl_o(ctrl_w)
    );

    assign inc_w = ctrl_w.invert ? dn_i : up_i;
    assign dec_w = ctrl_w.invert ? up_i : dn_i;

    cgf_accum #(.ACC_W(ACC_W), .GAIN_W(GAIN_W)) accum_i (
        .clk(clk), .rst_n(rst_n), .inc_i(inc_w), .dec_i(dec_w),
        .freeze_i(ctrl_w.freeze), .gain_i(gain_w), .acc_o(acc_w)
    );

    cgf_dsm #(.FRAC_W(FRAC_W), .FINE_W(FINE_W)) dsm_i (
        .clk(clk), .rst_n(rst_n), .en_i(ctrl_w.dither),
        .frac_i(acc_w[FRAC_W-1:0]), .fine_i(acc_w[FRAC_W +: FINE_W]),
        .fine_o(fine_w)
    );

    cgf_therm #(.IN_W(THERM_W)) therm_i (
        .code_i(fine_w[FINE_W-1 -: THERM_W]), .lines_o(therm_w)
    );

    always_comb begin
        out_d.coarse = acc_w[ACC_W-1 -: COARSE_W];
        out_d.bin    = fine_w[BIN_W-1:0];
        out_d.therm  = therm_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q.coarse <= COARSE_RST;
            out_q.bin    <= '0;
            out_q.therm  <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign coarse_o     = out_q.coarse;
    assign fine_bin_o   = out_q.bin;
    assign fine_therm_o = out_q.therm;

    p_coarse_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> coarse_o == $past(acc_w[ACC_W-1 -: COARSE_W]));
    p_therm_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((fine_therm_o & (fine_therm_o + LINES'(1))) == '0));
    p_invert_dir_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_w.invert && !ctrl_w.freeze && up_i && !dn_i && acc_w != '0)
        |=> acc_w < $past(acc_w) || $past(gain_w) == '0);
endmodule

// File: tb/cg_loop_filter_tb_top.sv
module cg_loop_filter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       up_i = 1'b0, dn_i = 1'b0, cfg_we_i = 1'b0;
    logic [1:0] cfg_addr_i = '0;
    logic [7:0] cfg_wdata_i = '0;
    logic [5:0] coarse_o;
    logic [1:0] fine_bin_o;
    logic [6:0] fine_therm_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;
    string phase = "R1";

    always #2.5 clk = ~clk;

    cg_loop_filter dut_i (
        .clk(clk), .rst_n(rst_n), .up_i(up_i), .dn_i(dn_i),
        .cfg_we_i(cfg_we_i), .cfg_addr_i(cfg_addr_i), .cfg_wdata_i(cfg_wdata_i),
        .coarse_o(coarse_o), .fine_bin_o(fine_bin_o), .fine_therm_o(fine_therm_o)
    );

    // cycle model built from the requirements
    logic [15:0] m_acc;
    logic [7:0]  m_gain;
    logic [2:0]  m_ctrl;
    logic [4:0]  m_frac;
    logic [5:0]  m_coarse;
    logic [4:0]  m_fine;

    function automatic logic [15:0] next_acc(logic [15:0] a, logic [7:0] g,
                                             logic [2:0] c, logic u, logic d);
        logic iu, id;
        int   t;
        iu = c[2] ? d : u;
        id = c[2] ? u : d;
        if (c[1] || iu == id) return a;
        t = iu ? int'(a) + int'(g) : int'(a) - int'(g);
        if (t > 65535) t = 65535;
        if (t < 0) t = 0;
        return 16'(t);
    endfunction

    function automatic logic [6:0] therm_of(logic [2:0] k);
        return 7'((8'd1 << k) - 8'd1);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_acc <= 16'h8000; m_gain <= 8'd1; m_ctrl <= 3'd0;
            m_frac <= 5'd0; m_coarse <= 6'd32; m_fine <= 5'd0;
        end else begin
            int fs;
            int fn;
            fs = int'(m_frac) + int'(m_acc[4:0]);
            fn = int'(m_acc[9:5]) + ((m_ctrl[0] && fs >= 32) ? 1 : 0);
            if (fn > 31) fn = 31;
            m_frac   <= m_ctrl[0] ? 5'(fs) : 5'd0;
            m_fine   <= 5'(fn);
            m_coarse <= m_acc[15:10];
            m_acc    <= next_acc(m_acc, m_gain, m_ctrl, up_i, dn_i);
            if (cfg_we_i && cfg_addr_i == 2'd0) m_gain <= cfg_wdata_i;
            if (cfg_we_i && cfg_addr_i == 2'd1) m_ctrl <= cfg_wdata_i[2:0];
        end
    end

    task automatic expect_eq(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_all();
        expect_eq({phase, "/R4 coarse"}, coarse_o, m_coarse);
        expect_eq({phase, "/R5 binary"}, fine_bin_o, m_fine[1:0]);
        expect_eq({phase, "/R5 therm"}, fine_therm_o, therm_of(m_fine[4:2]));
    endtask

    task automatic step(logic u, logic d);
        up_i = u; dn_i = d;
        @(posedge clk); @(negedge clk);
        up_i = 1'b0; dn_i = 1'b0;
        check_all();
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] v);
        cfg_we_i = 1'b1; cfg_addr_i = a; cfg_wdata_i = v;
        @(posedge clk); @(negedge clk);
        cfg_we_i = 1'b0;
        check_all();
    endtask

    initial begin
        int seed;
        seed = 1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R1: reset values
        expect_eq("R1 coarse", coarse_o, 32);
        expect_eq("R1 binary", fine_bin_o, 0);
        expect_eq("R1 therm", fine_therm_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_all();

        // R2: one fine step per up with gain 32
        phase = "R2";
        wr(2'd0, 8'd32);
        step(1'b1, 1'b0); step(1'b0, 1'b0);
        expect_eq("R2 fine up", fine_bin_o, 1);
        step(1'b1, 1'b1); step(1'b0, 1'b0);
        expect_eq("R2 both hold", fine_bin_o, 1);
        step(1'b0, 1'b1); step(1'b0, 1'b0);
        expect_eq("R2 fine down", fine_bin_o, 0);

        // R7: ignored addresses leave gain and control untouched
        phase = "R7";
        wr(2'd2, 8'hFF); wr(2'd3, 8'h07);
        step(1'b1, 1'b0); step(1'b0, 1'b0);
        expect_eq("R7 ignored write", fine_bin_o, 1);

        // R3: top and bottom rails
        phase = "R3";
        wr(2'd0, 8'd255);
        repeat (300) step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        expect_eq("R3 top coarse", coarse_o, 63);
        expect_eq("R3 top fine", {fine_therm_o, fine_bin_o}, {7'h7F, 2'd3});
        // R6: dither at top must not wrap the fine code
        phase = "R6";
        wr(2'd1, 8'd1);
        repeat (8) step(1'b0, 1'b0);
        expect_eq("R6 fine saturates", {fine_therm_o, fine_bin_o}, {7'h7F, 2'd3});
        wr(2'd1, 8'd0);
        phase = "R3";
        repeat (300) step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        expect_eq("R3 bottom coarse", coarse_o, 0);
        expect_eq("R3 bottom therm", fine_therm_o, 0);

        // R8: freeze holds the accumulator
        phase = "R8";
        wr(2'd0, 8'd200);
        wr(2'd1, 8'd2);
        repeat (20) step(1'b1, 1'b0);
        expect_eq("R8 frozen coarse", coarse_o, 0);
        // R9: inverted polarity, dn raises
        phase = "R9";
        wr(2'd1, 8'd4);
        repeat (20) step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        expect_eq("R9 inverted raises", int'(coarse_o > 0), 1);

        // R6: dither with half fraction toggles fine code
        phase = "R6";
        wr(2'd1, 8'd1);
        repeat (200) step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));

        // random mix
        phase = "R2";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 19) == 0) begin
                cfg_we_i = 1'b1;
                cfg_addr_i = 2'($urandom_range(0, 3));
                cfg_wdata_i = (cfg_addr_i == 2'd1) ? 8'($urandom_range(0, 7))
                                                   : 8'($urandom_range(0, 255));
            end
            up_i = 1'($urandom_range(0, 1));
            dn_i = 1'($urandom_range(0, 1));
            @(posedge clk); @(negedge clk);
            cfg_we_i = 1'b0;
            check_all();
        end
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_checks++; n_errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule